// File: doc/BRIEF.md
# Chunk-Serial Wide Unsigned Adder

This block sums two wide unsigned operands, 256 bits each by default, with one narrow adder reused over several clock cycles. A pulse on `start` while the block is idle captures both full-width operands. The block then emits the sum as a stream of 32-bit result chunks. The lowest-weight chunk comes first, and one chunk leaves on each accepted transfer.

Each chunk is formed as a 33-bit sum of the two operand slices plus a carry bit. The top bit of that sum is held in a flip-flop and becomes the carry into the following chunk, so no combinational path is longer than one 32-bit add. The carry into the first chunk is zero. The final chunk is marked by `done`, and `carry_out` presents the carry out of the whole addition next to it.

The result stream uses a valid/ready handshake. A chunk is transferred in a cycle where `res_valid` and `res_ready` are both high. While `res_ready` is low, the block holds the chunk on offer, its `done` and `carry_out` unchanged, and the internal carry and chunk position do not move. With `res_ready` held high, the chunks come out on consecutive cycles. `start` is a plain strobe with no handshake. It is only accepted while no result stream is pending.

Top module: `wide_chunk_adder`

## Requirements
- R1: After reset, `res_valid`, `done` and `carry_out` are low.
- R2: A `start` sampled while idle captures `op_a` and `op_b`. The first result chunk is offered in the very next cycle, and later changes on the operand inputs do not affect the result.
- R3: Transfer k (counted from 0) carries bits [32k+31:32k] of the sum `op_a + op_b`, in increasing order of k.
- R4: The carry into chunk 0 is zero, and the carry out of every chunk reaches the next chunk. For example, all-ones plus one yields all-zero chunks and a final carry of 1.
- R5: Exactly OP_W/CHUNK_W chunks are offered per addition. `done` is high only while the last of them is offered.
- R6: `carry_out` equals bit OP_W of the full sum while `done` is high, and is 0 at all other times.
- R7: While `res_valid` is high and `res_ready` is low, `res_chunk`, `done` and `carry_out` hold their values and no chunk is consumed.
- R8: `start` is ignored while a result stream is pending, including the cycle in which the last chunk is transferred.
- R9: With `res_ready` held high, an addition completes in OP_W/CHUNK_W consecutive cycles, and `res_valid` is low in the cycle after the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an addition, honoured only when idle |
| op_a | input | OP_W | First unsigned operand, sampled with start |
| op_b | input | OP_W | Second unsigned operand, sampled with start |
| res_valid | output | 1 | A result chunk is offered |
| res_ready | input | 1 | Consumer accepts the offered chunk |
| res_chunk | output | CHUNK_W | Current result chunk |
| done | output | 1 | The offered chunk is the last one |
| carry_out | output | 1 | Carry out of the full sum, meaningful with done |

## Verification
Two events can fall in the same cycle: a new `start` and the transfer of the final chunk. Another overlap is a `start` during a back-pressure stall on any chunk. The bench holds `start` high with fresh operands throughout a run under random stalls. It then judges that every chunk still matches the first operands and that `res_valid` falls after the last transfer. A second, narrow instance is swept over every operand pair, so that every carry chain between chunks is covered.

// File: rtl/wca_pkg.sv
package wca_pkg;
  typedef enum logic {
    WCA_IDLE = 1'b0,
    WCA_RUN  = 1'b1
  } wca_state_e;
endpackage

// File: rtl/wca_chunk_add.sv
module wca_chunk_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
  end
endmodule

// File: rtl/wca_operand_shift.sv
module wca_operand_shift #(
  parameter int OP_W    = 256,
  parameter int CHUNK_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [OP_W-1:0]    din,
  output logic [CHUNK_W-1:0] low
);
  logic [OP_W-1:0] hold_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (load)  hold_q <= din;
    else if (shift) hold_q <= hold_q >> CHUNK_W;
  end
  assign low = hold_q[CHUNK_W-1:0];
endmodule

// File: rtl/wca_seq.sv
module wca_seq
  import wca_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready,
  output logic busy,
  output logic load,
  output logic advance,
  output logic last
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  wca_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    busy    = (state_q == WCA_RUN);
    load    = (state_q == WCA_IDLE) && start;
    advance = busy && ready;
    last    = busy && (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WCA_IDLE;
      idx_q   <= '0;
    end else if (load) begin
      state_q <= WCA_RUN;
      idx_q   <= '0;
    end else if (advance) begin
      if (last) state_q <= WCA_IDLE;
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/wide_chunk_adder.sv
module wide_chunk_adder #(
  parameter int OP_W    = 256,
  parameter int CHUNK_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [OP_W-1:0]    op_a,
  input  logic [OP_W-1:0]    op_b,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [CHUNK_W-1:0] res_chunk,
  output logic               done,
  output logic               carry_out
);
  localparam int N_CHUNKS = OP_W / CHUNK_W;

  logic busy, load, advance, last;
  logic carry_q, cout;
  logic [CHUNK_W-1:0] slice [2];
  logic [OP_W-1:0]    opnd  [2];

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  wca_seq #(.N(N_CHUNKS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(res_ready),
    .busy(busy), .load(load), .advance(advance), .last(last)
  );

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    wca_operand_shift #(.OP_W(OP_W), .CHUNK_W(CHUNK_W)) sh_i (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(advance),
      .din(opnd[g]), .low(slice[g])
    );
  end

  wca_chunk_add #(.W(CHUNK_W)) add_i (
    .a(slice[0]), .b(slice[1]), .cin(carry_q),
    .sum(res_chunk), .cout(cout)
  );

  // Carry between chunks is registered: zero for chunk 0 (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       carry_q <= 1'b0;
    else if (load)    carry_q <= 1'b0;
    else if (advance) carry_q <= cout;
  end

  assign res_valid = busy;
  assign done      = last;
  assign carry_out = last & cout;
endmodule

// File: rtl/wca_checker.sv
module wca_checker #(
  parameter int OP_W    = 256,
  parameter int CHUNK_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               res_valid,
  input logic               res_ready,
  input logic [CHUNK_W-1:0] res_chunk,
  input logic               done,
  input logic               carry_out
);
  localparam int N = OP_W / CHUNK_W;
  int unsigned beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats <= 0;
    else if (res_valid && res_ready) beats <= done ? 0 : beats + 1;
  end

  assert_done_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);
  assert_done_position_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (done == (beats == N - 1)));
  assert_carry_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !carry_out);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_chunk) && $stable(done) && $stable(carry_out)));
  assert_busy_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(done && res_ready)) |=> res_valid);
  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_ready) |=> !res_valid);
  assert_start_offers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && start) |=> res_valid);
endmodule

bind wide_chunk_adder wca_checker #(.OP_W(OP_W), .CHUNK_W(CHUNK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid),
  .res_ready(res_ready), .res_chunk(res_chunk), .done(done), .carry_out(carry_out)
);

// File: tb/wide_chunk_adder_tb_top.sv
module wide_chunk_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 256;
  localparam int CW   = 32;
  localparam int N    = OP_W / CW;
  localparam int S_OP = 6;
  localparam int S_CW = 2;
  localparam int S_N  = S_OP / S_CW;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            start = 0, res_ready = 1;
  logic [OP_W-1:0] op_a = '0, op_b = '0;
  logic            res_valid, done, carry_out;
  logic [CW-1:0]   res_chunk;

  logic            s_start = 0;
  logic [S_OP-1:0] s_a = '0, s_b = '0;
  logic            s_valid, s_done, s_carry;
  logic [S_CW-1:0] s_chunk;

  int n_chk = 0, n_fail = 0;

  wide_chunk_adder #(.OP_W(OP_W), .CHUNK_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_chunk(res_chunk),
    .done(done), .carry_out(carry_out)
  );

  wide_chunk_adder #(.OP_W(S_OP), .CHUNK_W(S_CW)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .start(s_start), .op_a(s_a), .op_b(s_b),
    .res_valid(s_valid), .res_ready(1'b1), .res_chunk(s_chunk),
    .done(s_done), .carry_out(s_carry)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [OP_W:0] act, input logic [OP_W:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [OP_W-1:0] rand_wide();
    logic [OP_W-1:0] v;
    for (int i = 0; i < N; i++) v[i*CW +: CW] = $urandom;
    return v;
  endfunction

  task automatic big_add(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                         input int stall_pct, input bit poke);
    logic [OP_W:0] sum_ref;
    int k, cyc;
    sum_ref = {1'b0, a} + {1'b0, b};
    k = 0; cyc = 0;
    @(negedge clk);
    op_a = a; op_b = b; start = 1; res_ready = 1;
    @(negedge clk);
    start = 0; op_a = rand_wide(); op_b = rand_wide();
    check(res_valid == 1'b1, "R2", "first chunk offered", res_valid, 1);
    while (k < N && cyc < 400) begin
      res_ready = ($urandom_range(99) >= stall_pct);
      start = poke;
      if (!res_valid) begin
        check(0, "R9", "valid dropped mid-run", 0, 1);
      end else begin
        check(res_chunk == sum_ref[k*CW +: CW],
              !res_ready ? "R7" : (k == 0 ? "R4" : "R3"), "chunk value",
              res_chunk, sum_ref[k*CW +: CW]);
        check(done == (k == N-1), "R5", "done position", done, (k == N-1));
        check(carry_out == ((k == N-1) ? sum_ref[OP_W] : 1'b0), "R6",
              "carry_out", carry_out, (k == N-1) ? sum_ref[OP_W] : 1'b0);
        if (res_ready) k++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; res_ready = 1;
    check(!res_valid, poke ? "R8" : "R9", "idle after last transfer", res_valid, 0);
    if (stall_pct == 0) check(cyc == N, "R9", "cycles for full add", cyc, N);
  endtask

  task automatic small_add(input int a, input int b);
    logic [S_OP:0] got;
    bit flags_ok;
    int exp;
    exp = a + b;
    flags_ok = 1;
    got = '0;
    @(negedge clk);
    s_a = S_OP'(a); s_b = S_OP'(b); s_start = 1;
    @(negedge clk);
    s_start = 0;
    for (int j = 0; j < S_N; j++) begin
      got[j*S_CW +: S_CW] = s_chunk;
      if (!s_valid || s_done != (j == S_N-1)) flags_ok = 0;
      if (j == S_N-1) got[S_OP] = s_carry;
      else if (s_carry) flags_ok = 0;
      @(negedge clk);
    end
    if (s_valid) flags_ok = 0;
    check(flags_ok && (got == (S_OP+1)'(exp)), "R3", "narrow sweep sum",
          got, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R9): actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!res_valid && !done && !carry_out, "R1", "outputs in reset",
          {res_valid, done, carry_out}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!res_valid && !done && !carry_out, "R1", "outputs after reset",
          {res_valid, done, carry_out}, 0);
    // R4: all-ones plus one ripples a carry through every chunk
    big_add({OP_W{1'b1}}, {{(OP_W-1){1'b0}}, 1'b1}, 0, 0);
    big_add({OP_W{1'b1}}, {OP_W{1'b1}}, 0, 0);
    big_add('0, '0, 0, 0);
    big_add({{(OP_W-CW){1'b0}}, {CW{1'b1}}}, {{(OP_W-1){1'b0}}, 1'b1}, 0, 0);
    for (int i = 0; i < 10; i++) big_add(rand_wide(), rand_wide(), 0, 0);
    // R7: random back-pressure
    for (int i = 0; i < 10; i++) big_add(rand_wide(), rand_wide(), 50, 0);
    // R8: start held high with new operands during the whole run
    for (int i = 0; i < 6; i++) big_add(rand_wide(), rand_wide(), 40, 1);
    big_add({OP_W{1'b1}}, {{(OP_W-1){1'b0}}, 1'b1}, 0, 1);
    // R3: exhaustive sweep of the narrow instance
    for (int a = 0; a < (1 << S_OP); a++)
      for (int b = 0; b < (1 << S_OP); b++)
        small_add(a, b);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule